// File: doc/BRIEF.md
# Halfword Store Unit with Exception Screening

This block carries out one store-halfword operation for a small 32-bit processor that can run with virtual memory switched on. It adds a base register value to a sign-extended 16-bit offset to form the byte address. It then screens the access against three exception conditions, always in the same priority. If none of them applies, it drives a halfword write with byte enables onto a big-endian data memory port. If one applies, it suppresses the write, records the cause in the exception status fields and, where required, saves and clears the machine mode bits.

The surrounding pipeline supplies the operands, the current user and virtual mode bits, and the results of the translation lookup and the protection check. It receives a done pulse, a one-cycle exception pulse and the updated status fields. The `AREA_OPT` parameter selects the latency: 1 cycle when it is 0, 2 cycles when it is 1.

Top module: `half_store_exc`

## Requirements
- R1: The byte address on `mem_addr_o` is `base_i` plus `imm_i` sign-extended to 32 bits, with the sum wrapping modulo 2^32.
- R2: When no exception is raised, `mem_we_o` pulses for one cycle. If address bit 1 is 0, `mem_be_o` is 4'b1100 and `src_val_i[15:0]` appears on `mem_wdata_o[31:16]`. If address bit 1 is 1, `mem_be_o` is 4'b0011 and the halfword appears on `mem_wdata_o[15:0]`. The unused half of `mem_wdata_o` is zero.
- R3: The checks run in a fixed priority. With `vm_i`=1 and `tlb_hit_i`=0, a translation miss is raised with cause 5'b10010, whatever the protection and alignment inputs are.
- R4: With `vm_i`=1, a translation hit and a fault, a protection fault is raised with cause 5'b10000. A fault means `prot_ro_i`=1, or `prot_na_i`=1 while `um_i`=1. `esr_zone_o` records 1 for a no-access fault and 0 for a read-only fault. A no-access fault takes precedence when both apply.
- R5: A no-access indication while `um_i`=0 does not cause a fault.
- R6: With `vm_i`=0, the `tlb_hit_i`, `prot_ro_i` and `prot_na_i` inputs have no effect.
- R7: If no higher exception applies and address bit 0 is 1, a misalignment exception is raised with cause 5'b00001. `esr_wide_o` is set to 0 and `esr_rx_o` is set to `src_idx_i`.
- R8: Every exception sets `esr_store_o` to 1, pulses `exc_o` for one cycle and asserts no memory write.
- R9: On a translation miss or a protection fault, `msr_we_o` pulses. `ums_o` and `vms_o` take the operation's `um_i` and `vm_i`, and `um_o` and `vm_o` are 0. In every other case `msr_we_o` stays 0, and `um_o` and `vm_o` echo the operation's mode bits.
- R10: Exception status fields that the taken exception does not write keep their previous values. They also keep them across writes and idle cycles.
- R11: `done_o` rises exactly 1 cycle after `start_i` when `AREA_OPT`=0, and 2 cycles after when `AREA_OPT`=1. Back-to-back operations are accepted every cycle.
- R12: During and after reset, before any operation, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation valid this cycle |
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Signed offset |
| src_val_i | input | 32 | Source register value; the low half is stored |
| src_idx_i | input | 5 | Source register index |
| um_i | input | 1 | Current user-mode bit |
| vm_i | input | 1 | Current virtual-mode bit |
| tlb_hit_i | input | 1 | Translation found for the address |
| prot_ro_i | input | 1 | Address lies in a read-only zone |
| prot_na_i | input | 1 | Address lies in a no-access zone |
| done_o | output | 1 | Operation completed |
| mem_we_o | output | 1 | Memory write strobe |
| mem_be_o | output | 4 | Byte enables, big-endian lanes |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data |
| exc_o | output | 1 | Exception pulse |
| esr_cause_o | output | 5 | Exception cause code |
| esr_store_o | output | 1 | Exception came from a store |
| esr_zone_o | output | 1 | Protection fault kind, 1 for no-access |
| esr_wide_o | output | 1 | Access size of a misalignment, 0 for halfword |
| esr_rx_o | output | 5 | Register index of a misalignment |
| msr_we_o | output | 1 | Machine status update strobe |
| um_o | output | 1 | New user-mode bit |
| vm_o | output | 1 | New virtual-mode bit |
| ums_o | output | 1 | Saved user-mode bit |
| vms_o | output | 1 | Saved virtual-mode bit |

## Verification
The bench targets the priority corners. These include a translation miss on an odd address with a read-only zone also flagged, and a no-access indication outside user mode. A design that ranked the checks wrongly would report cause 5'b10000 or 5'b00001 where 5'b10010 is due. A design that ignored the user-mode qualifier would block a legal write. Negative offsets and an address that wraps past 2^32 expose a zero-extended or truncated adder. Addresses on both halfword lanes expose swapped byte enables. Sequences of mixed exceptions expose a status register that clears fields the current exception does not own, such as the zone bit after a misalignment.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned IMM_W      = 16;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned RIDX_W     = 5;
  localparam int unsigned CAUSE_W    = 5;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned LANES      = DATA_W / HALF_W;
  localparam int unsigned BE_W       = DATA_W / BYTE_W;
  localparam int unsigned HALF_BYTES = HALF_W / BYTE_W;
  localparam int unsigned LANE_BITS  = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int unsigned LANE_LSB   = $clog2(HALF_BYTES);

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE  = 5'b00000,
    CAUSE_ALIGN = 5'b00001,
    CAUSE_PROT  = 5'b10000,
    CAUSE_TLB   = 5'b10010
  } cause_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_TLB,
    EV_PROT,
    EV_ALIGN
  } event_e;

  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic [HALF_W-1:0] data;
    logic [RIDX_W-1:0] idx;
    logic              tlb_hit;
    logic              ro;
    logic              na;
    logic              um;
    logic              vm;
  } req_t;
endpackage

// File: rtl/hsx_agen.sv
module hsx_agen
  import hsx_pkg::*;
#(
  parameter bit AREA_OPT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [HALF_W-1:0] data_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic              tlb_hit_i,
  input  logic              ro_i,
  input  logic              na_i,
  input  logic              um_i,
  input  logic              vm_i,
  output req_t              req_o
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  req_t req_d;

  always_comb begin
    req_d.valid   = valid_i;
    req_d.addr    = base_i + {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    req_d.data    = data_i;
    req_d.idx     = idx_i;
    req_d.tlb_hit = tlb_hit_i;
    req_d.ro      = ro_i;
    req_d.na      = na_i;
    req_d.um      = um_i;
    req_d.vm      = vm_i;
  end

  // area variant: address stage registered, adder off the screening path
  generate
    if (AREA_OPT) begin : g_staged
      req_t req_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= '0;
        else         req_q <= req_d;
      end
      assign req_o = req_q;
    end else begin : g_direct
      assign req_o = req_d;
    end
  endgenerate
endmodule

// File: rtl/hsx_screen.sv
module hsx_screen
  import hsx_pkg::*;
(
  input  req_t   req_i,
  output event_e ev_o,
  output logic   zone_o
);
  logic prot_hit;
  logic unused_req;

  assign unused_req = ^{req_i.data, req_i.idx, req_i.addr[ADDR_W-1:1]};
  // no-access zone only counts in user mode
  assign zone_o   = req_i.na & req_i.um;
  assign prot_hit = req_i.ro | zone_o;

  always_comb begin
    ev_o = EV_NONE;
    if (req_i.valid) begin
      if (req_i.vm && !req_i.tlb_hit)  ev_o = EV_TLB;
      else if (req_i.vm && prot_hit)   ev_o = EV_PROT;
      else if (req_i.addr[0])          ev_o = EV_ALIGN;
    end
  end
endmodule

// File: rtl/hsx_lane.sv
module hsx_lane
  import hsx_pkg::*;
(
  input  logic [LANE_BITS-1:0] lane_i,
  input  logic [HALF_W-1:0]    data_i,
  output logic [BE_W-1:0]      be_o,
  output logic [DATA_W-1:0]    wdata_o
);
  // big-endian: lane 0 is the most significant half
  always_comb begin
    be_o    = '0;
    wdata_o = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_i == LANE_BITS'(k)) begin
        be_o[(LANES-1-k)*HALF_BYTES +: HALF_BYTES] = '1;
        wdata_o[(LANES-1-k)*HALF_W +: HALF_W]      = data_i;
      end
    end
  end
endmodule

// File: rtl/hsx_status.sv
module hsx_status
  import hsx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  event_e            ev_i,
  input  logic              zone_i,
  input  logic [RIDX_W-1:0] idx_i,
  input  logic              um_i,
  input  logic              vm_i,
  output logic              exc_o,
  output cause_e            cause_o,
  output logic              store_o,
  output logic              zone_o,
  output logic              wide_o,
  output logic [RIDX_W-1:0] rx_o,
  output logic              msr_we_o,
  output logic              um_o,
  output logic              vm_o,
  output logic              ums_o,
  output logic              vms_o
);
  logic mm_exc;
  assign mm_exc = (ev_i == EV_TLB) || (ev_i == EV_PROT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_o    <= 1'b0;
      cause_o  <= CAUSE_NONE;
      store_o  <= 1'b0;
      zone_o   <= 1'b0;
      wide_o   <= 1'b0;
      rx_o     <= '0;
      msr_we_o <= 1'b0;
      um_o     <= 1'b0;
      vm_o     <= 1'b0;
      ums_o    <= 1'b0;
      vms_o    <= 1'b0;
    end else begin
      exc_o    <= (ev_i != EV_NONE);
      msr_we_o <= mm_exc;
      if (valid_i) begin
        um_o <= mm_exc ? 1'b0 : um_i;
        vm_o <= mm_exc ? 1'b0 : vm_i;
      end
      if (mm_exc) begin
        ums_o <= um_i;
        vms_o <= vm_i;
      end
      unique case (ev_i)
        EV_TLB: begin
          cause_o <= CAUSE_TLB;
          store_o <= 1'b1;
        end
        EV_PROT: begin
          cause_o <= CAUSE_PROT;
          store_o <= 1'b1;
          zone_o  <= zone_i;
        end
        EV_ALIGN: begin
          cause_o <= CAUSE_ALIGN;
          store_o <= 1'b1;
          wide_o  <= 1'b0;
          rx_o    <= idx_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/half_store_exc.sv
module half_store_exc
  import hsx_pkg::*;
#(
  parameter bit AREA_OPT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] src_val_i,
  input  logic [RIDX_W-1:0] src_idx_i,
  input  logic              um_i,
  input  logic              vm_i,
  input  logic              tlb_hit_i,
  input  logic              prot_ro_i,
  input  logic              prot_na_i,
  output logic              done_o,
  output logic              mem_we_o,
  output logic [BE_W-1:0]   mem_be_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              exc_o,
  output logic [CAUSE_W-1:0] esr_cause_o,
  output logic              esr_store_o,
  output logic              esr_zone_o,
  output logic              esr_wide_o,
  output logic [RIDX_W-1:0] esr_rx_o,
  output logic              msr_we_o,
  output logic              um_o,
  output logic              vm_o,
  output logic              ums_o,
  output logic              vms_o
);
  req_t              req;
  event_e            ev;
  logic              zone;
  logic [BE_W-1:0]   be;
  logic [DATA_W-1:0] wdata;
  cause_e            cause;
  logic              do_write;
  logic              unused_src_hi;

  assign unused_src_hi = ^src_val_i[DATA_W-1:HALF_W];

  hsx_agen #(.AREA_OPT(AREA_OPT)) i_agen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (start_i),
    .base_i    (base_i),
    .imm_i     (imm_i),
    .data_i    (src_val_i[HALF_W-1:0]),
    .idx_i     (src_idx_i),
    .tlb_hit_i (tlb_hit_i),
    .ro_i      (prot_ro_i),
    .na_i      (prot_na_i),
    .um_i      (um_i),
    .vm_i      (vm_i),
    .req_o     (req)
  );

  hsx_screen i_screen (
    .req_i  (req),
    .ev_o   (ev),
    .zone_o (zone)
  );

  hsx_lane i_lane (
    .lane_i  (req.addr[LANE_LSB +: LANE_BITS]),
    .data_i  (req.data),
    .be_o    (be),
    .wdata_o (wdata)
  );

  hsx_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (req.valid),
    .ev_i     (ev),
    .zone_i   (zone),
    .idx_i    (req.idx),
    .um_i     (req.um),
    .vm_i     (req.vm),
    .exc_o    (exc_o),
    .cause_o  (cause),
    .store_o  (esr_store_o),
    .zone_o   (esr_zone_o),
    .wide_o   (esr_wide_o),
    .rx_o     (esr_rx_o),
    .msr_we_o (msr_we_o),
    .um_o     (um_o),
    .vm_o     (vm_o),
    .ums_o    (ums_o),
    .vms_o    (vms_o)
  );

  assign esr_cause_o = cause;
  assign do_write    = req.valid && (ev == EV_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_be_o    <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      done_o   <= req.valid;
      mem_we_o <= do_write;
      mem_be_o <= do_write ? be : '0;
      if (req.valid) mem_addr_o <= req.addr;
      if (do_write)  mem_wdata_o <= wdata;
    end
  end
endmodule

// File: rtl/hsx_checker.sv
module hsx_checker
  import hsx_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               done_o,
  input logic               mem_we_o,
  input logic [BE_W-1:0]    mem_be_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               exc_o,
  input logic [CAUSE_W-1:0] esr_cause_o,
  input logic               esr_store_o,
  input logic               esr_zone_o,
  input logic               esr_wide_o,
  input logic [RIDX_W-1:0]  esr_rx_o,
  input logic               msr_we_o,
  input logic               um_o,
  input logic               vm_o
);
  a_r8_no_write_on_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> !mem_we_o);

  a_r8_store_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> esr_store_o);

  a_r2_lane_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_be_o == 4'b1100 && !mem_addr_o[1]) || (mem_be_o == 4'b0011 && mem_addr_o[1])));

  a_r7_write_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_addr_o[0]);

  a_r3_cause_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (esr_cause_o == 5'b10010 || esr_cause_o == 5'b10000 || esr_cause_o == 5'b00001));

  a_r9_msr_mm_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msr_we_o |-> (exc_o && esr_cause_o != 5'b00001 && !um_o && !vm_o));

  a_r9_align_no_msr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o && esr_cause_o == 5'b00001) |-> !msr_we_o);

  a_r10_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_o |-> ($stable(esr_cause_o) && $stable(esr_store_o) && $stable(esr_zone_o)
                && $stable(esr_wide_o) && $stable(esr_rx_o)));

  a_r11_result_has_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || exc_o) |-> done_o);
endmodule

bind half_store_exc hsx_checker i_hsx_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .mem_we_o    (mem_we_o),
  .mem_be_o    (mem_be_o),
  .mem_addr_o  (mem_addr_o),
  .exc_o       (exc_o),
  .esr_cause_o (esr_cause_o),
  .esr_store_o (esr_store_o),
  .esr_zone_o  (esr_zone_o),
  .esr_wide_o  (esr_wide_o),
  .esr_rx_o    (esr_rx_o),
  .msr_we_o    (msr_we_o),
  .um_o        (um_o),
  .vm_o        (vm_o)
);

// File: tb/test_half_store_exc.sv
`timescale 1ns/1ps
module test_half_store_exc;
  localparam bit AREA_OPT = 1'b0;
  localparam int LAT      = AREA_OPT ? 2 : 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] src_val_i = '0;
  logic [4:0]  src_idx_i = '0;
  logic        um_i = 1'b0, vm_i = 1'b0, tlb_hit_i = 1'b0, prot_ro_i = 1'b0, prot_na_i = 1'b0;
  logic        done_o, mem_we_o, exc_o, esr_store_o, esr_zone_o, esr_wide_o;
  logic        msr_we_o, um_o, vm_o, ums_o, vms_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [4:0]  esr_cause_o, esr_rx_o;

  int vectors = 0;
  int fails   = 0;

  always #2 clk_i = ~clk_i;

  half_store_exc #(.AREA_OPT(AREA_OPT)) i_half_store_exc (.*);

  typedef struct {
    bit        done, exc, we;
    bit [3:0]  be;
    bit [31:0] addr, wdata;
    bit [4:0]  cause, rx;
    bit        store, zone, wide;
    bit        msr_we, um, vm, ums, vms;
    string     tag;
  } exp_t;

  exp_t q[$];
  bit [4:0] m_cause = 0, m_rx = 0;
  bit       m_store = 0, m_zone = 0, m_wide = 0;

  task automatic chk(string tag, string fld, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, fld, act, exp, $time);
    end
  endtask

  function automatic exp_t idle_exp(string tag);
    exp_t e;
    e.done = 0; e.exc = 0; e.we = 0; e.be = 0; e.addr = 0; e.wdata = 0;
    e.cause = m_cause; e.rx = m_rx; e.store = m_store; e.zone = m_zone; e.wide = m_wide;
    e.msr_we = 0; e.um = 0; e.vm = 0; e.ums = 0; e.vms = 0; e.tag = tag;
    return e;
  endfunction

  task automatic compare(exp_t e);
    chk(e.tag, "done", 32'(done_o), 32'(e.done));
    chk(e.tag, "exc", 32'(exc_o), 32'(e.exc));
    chk(e.tag, "we", 32'(mem_we_o), 32'(e.we));
    if (e.we) begin
      chk(e.tag, "be", 32'(mem_be_o), 32'(e.be));
      chk(e.tag, "addr", mem_addr_o, e.addr);
      chk(e.tag, "wdata", mem_wdata_o, e.wdata);
    end
    chk(e.tag, "cause", 32'(esr_cause_o), 32'(e.cause));
    chk(e.tag, "store", 32'(esr_store_o), 32'(e.store));
    chk(e.tag, "zone", 32'(esr_zone_o), 32'(e.zone));
    chk(e.tag, "wide", 32'(esr_wide_o), 32'(e.wide));
    chk(e.tag, "rx", 32'(esr_rx_o), 32'(e.rx));
    chk(e.tag, "msr_we", 32'(msr_we_o), 32'(e.msr_we));
    if (e.done) begin
      chk(e.tag, "um", 32'(um_o), 32'(e.um));
      chk(e.tag, "vm", 32'(vm_o), 32'(e.vm));
    end
    if (e.msr_we) begin
      chk(e.tag, "ums", 32'(ums_o), 32'(e.ums));
      chk(e.tag, "vms", 32'(vms_o), 32'(e.vms));
    end
  endtask

  // one cycle: check the matured expectation, then drive and model a new one
  task automatic step(bit st, bit [31:0] base, bit [15:0] imm, bit [31:0] src, bit [4:0] idx,
                      bit um, bit vm, bit hit, bit ro, bit na, string tag);
    exp_t e;
    bit [31:0] addr;
    @(negedge clk_i);
    compare(q.pop_front());
    start_i = st; base_i = base; imm_i = imm; src_val_i = src; src_idx_i = idx;
    um_i = um; vm_i = vm; tlb_hit_i = hit; prot_ro_i = ro; prot_na_i = na;
    addr = base + {{16{imm[15]}}, imm};
    if (st) begin
      if (vm && !hit) begin
        m_cause = 5'b10010; m_store = 1;
      end else if (vm && (ro || (na && um))) begin
        m_cause = 5'b10000; m_store = 1; m_zone = na && um;
      end else if (addr[0]) begin
        m_cause = 5'b00001; m_store = 1; m_wide = 0; m_rx = idx;
      end
    end
    e = idle_exp(tag);
    if (st) begin
      e.done = 1; e.addr = addr;
      if (vm && (!hit || ro || (na && um))) begin
        e.exc = 1; e.msr_we = 1; e.ums = um; e.vms = vm; e.um = 0; e.vm = 0;
      end else begin
        e.um = um; e.vm = vm;
        if (addr[0]) e.exc = 1;
        else begin
          e.we = 1;
          e.be    = addr[1] ? 4'b0011 : 4'b1100;
          e.wdata = addr[1] ? {16'h0, src[15:0]} : {src[15:0], 16'h0};
        end
      end
    end
    q.push_back(e);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    // R12: outputs at reset
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < LAT; i++) q.push_back(idle_exp("R12"));
    chk("R12", "we_in_reset", 32'(mem_we_o), 0);
    chk("R12", "cause_in_reset", 32'(esr_cause_o), 0);
    rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    // R1/R2: both lanes, negative offset, wraparound
    step(1, 32'h0000_1000, 16'h0004, 32'hDEAD_BEEF, 5'd3, 0, 0, 1, 0, 0, "R2");
    step(1, 32'h0000_2000, 16'hFFFE, 32'h1234_5678, 5'd4, 0, 0, 1, 0, 0, "R1");
    step(1, 32'hFFFF_FFF0, 16'h0020, 32'h0000_A5A5, 5'd5, 1, 0, 1, 0, 0, "R1");
    // R6: vm off, lookup and protection inputs ignored
    step(1, 32'h0000_3000, 16'h0002, 32'h0000_CAFE, 5'd6, 1, 0, 0, 1, 1, "R6");
    // R7: misaligned with vm off
    step(1, 32'h0000_3001, 16'h0000, 32'h0000_0001, 5'd13, 0, 0, 1, 0, 0, "R7");
    // R3: miss wins over protection and misalignment
    step(1, 32'h0000_4001, 16'h0000, 32'h0000_0002, 5'd9, 1, 1, 0, 1, 1, "R3");
    // R4: read-only fault, then no-access fault
    step(1, 32'h0000_5000, 16'h0000, 32'h0000_0003, 5'd10, 0, 1, 1, 1, 0, "R4");
    step(1, 32'h0000_5003, 16'h0000, 32'h0000_0004, 5'd11, 1, 1, 1, 1, 1, "R4");
    // R10: misalign keeps zone bit; miss keeps rx
    step(1, 32'h0000_6005, 16'h0000, 32'h0000_0005, 5'd21, 1, 0, 1, 0, 0, "R10");
    step(1, 32'h0000_6000, 16'h0000, 32'h0000_0006, 5'd22, 1, 1, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // R5: no-access outside user mode is not a fault
    step(1, 32'h0000_7000, 16'h0006, 32'h0000_BEEF, 5'd7, 0, 1, 1, 0, 1, "R5");
    // R9: mode bits saved and cleared
    step(1, 32'h0000_8000, 16'h0000, 32'h0, 5'd1, 1, 1, 1, 1, 0, "R9");
    // R8/R11: back-to-back mixed exceptions and writes
    step(1, 32'h0000_9001, 16'h0000, 32'h0, 5'd2, 0, 0, 1, 0, 0, "R8");
    step(1, 32'h0000_9002, 16'h0000, 32'h0000_1111, 5'd2, 0, 0, 1, 0, 0, "R11");
    step(1, 32'h0000_9004, 16'h0000, 32'h0000_2222, 5'd2, 0, 1, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    for (int n = 0; n < 600; n++) begin
      bit [31:0] r = $urandom;
      step(r[0] | r[1], $urandom, 16'($urandom), $urandom, 5'($urandom),
           r[2], r[3], r[4] | r[5], r[6] & r[7], r[8] & r[9], "RND");
    end
    for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule